// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the fetch side of a transmit DMA engine. Software lays out a ring of 8-byte descriptors in memory, each naming one buffer, and marks the ones it has filled as owned by hardware. It then writes a start command to the block. The walker reads the descriptor at its current ring position. If the ownership flag is set, it asks a memory reader for the buffer, using the descriptor's pointer and byte count. It passes the returned bytes on to the MAC and tags the final byte with that descriptor's frame and CRC flags. It then writes the status halfword back with ownership cleared and moves to the next slot.

Traversal is driven only by flags inside each descriptor. A wrap flag sends the next fetch back to the ring base. The first descriptor found without the ownership flag parks the walker until the next start command. Software learns that a buffer has gone by polling the ownership flag of its descriptor.

Top module: `txbd_walker`

## Requirements
- R1: After reset the walker asserts none of its request or valid outputs (`dfetch_req_o`, `bufrd_valid_o`, `tx_valid_o`, `swb_req_o`) and waits for a start command.
- R2: A write on the start port with bit 24 of the data set starts polling from idle. A write with bit 24 clear has no effect. A descriptor fetch reads 8 bytes at `{ring_base_i[31:4], 4'b0} + 8*index`, so the low four bits of the base register are ignored. The index is 0 after reset.
- R3: A fetched 64-bit word holds status in bits [63:48], byte count in [47:32] and buffer pointer in [31:0]. Status bit 15 means the descriptor is owned by hardware.
- R4: For an owned descriptor with a nonzero count, exactly one buffer read request is issued. Its address is the pointer and its length is the count.
- R5: Buffer bytes reach the transmit port unchanged and in order, one per handshake, with back-pressure from the transmit side carried through to the byte source.
- R6: The byte that completes the count carries `tx_end_o`. On that byte only, `tx_frame_last_o`, `tx_add_crc_o` and `tx_bad_crc_o` copy status bits 11, 10 and 9. On every other byte all four sideband outputs are 0.
- R7: When a buffer has been consumed, a 16-bit status write goes to the descriptor's own address. It carries the fetched status with bit 15 cleared and every other bit unchanged.
- R8: After the status write the next fetch is at the following slot (+8 bytes), or at the ring base when status bit 13 (wrap) was set.
- R9: A fetched descriptor with bit 15 clear stops the walker with no further fetch until a start command. A start command that arrives while the walker is busy is not lost.
- R10: An owned descriptor with a count of 0 issues no buffer read and goes straight to its status write.
- R11: At most one of descriptor fetch, buffer request, byte transfer and status write is active in any cycle. A pending request holds its address and data stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base_i | input | 32 | Ring base address register (16-byte aligned) |
| db_we_i | input | 1 | Start-command register write strobe |
| db_wdata_i | input | 32 | Start-command write data; bit 24 starts polling |
| dfetch_req_o | output | 1 | Descriptor read request |
| dfetch_addr_o | output | 32 | Descriptor address |
| dfetch_ack_i | input | 1 | Descriptor read accepted, data valid |
| dfetch_data_i | input | 64 | Descriptor word |
| bufrd_valid_o | output | 1 | Buffer read request valid |
| bufrd_ready_i | input | 1 | Buffer read request accepted |
| bufrd_addr_o | output | 32 | Buffer start address |
| bufrd_len_o | output | 16 | Buffer byte count |
| src_valid_i | input | 1 | Buffer byte valid from the memory reader |
| src_data_i | input | 8 | Buffer byte |
| src_ready_o | output | 1 | Buffer byte accepted |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Transmit side ready |
| tx_data_o | output | 8 | Transmit byte |
| tx_end_o | output | 1 | Final byte of this buffer |
| tx_frame_last_o | output | 1 | Buffer ends a frame (final byte only) |
| tx_add_crc_o | output | 1 | MAC appends FCS (final byte only) |
| tx_bad_crc_o | output | 1 | MAC appends a corrupted FCS (final byte only) |
| swb_req_o | output | 1 | Status write-back request |
| swb_addr_o | output | 32 | Status write-back address |
| swb_data_o | output | 16 | Status halfword to write |
| swb_ack_i | input | 1 | Status write accepted |

## Verification
Assertions check the cycle-level rules on every cycle:
- the four activities never overlap;
- pending fetch, buffer and write requests hold still until accepted;
- descriptor addresses stay 8-byte aligned;
- the written status never has bit 15 set;
- non-final bytes carry no sideband;
- no buffer request has a zero length.

Whole-ring behaviour can only be shown by the bench's scenarios. These cover address order across a wrap, the exact bytes and their tags, the stop at an unowned descriptor, start writes without bit 24, and a start command that arrives mid-buffer. A bench model of the ring memory predicts every fetch, request, byte and write-back.

// File: rtl/txbd_pkg.sv
`timescale 1ns/1ps
package txbd_pkg;
  localparam int TXBD_AW      = 32;
  localparam int TXBD_LW      = 16;
  localparam int TXBD_SW      = 16;
  localparam int TXBD_DESC_W  = TXBD_SW + TXBD_LW + TXBD_AW;
  localparam int ST_OWN       = 15;
  localparam int ST_WRAP      = 13;
  localparam int ST_LAST      = 11;
  localparam int ST_TXCRC     = 10;
  localparam int ST_BADCRC    = 9;

  typedef enum logic [2:0] {
    W_IDLE,
    W_FETCH,
    W_CHECK,
    W_BREQ,
    W_STREAM,
    W_WBACK
  } walk_state_e;

  typedef struct packed {
    logic [TXBD_SW-1:0] status;
    logic [TXBD_LW-1:0] len;
    logic [TXBD_AW-1:0] ptr;
  } txbd_desc_t;
endpackage

// File: rtl/txbd_ring_addr.sv
`timescale 1ns/1ps
module txbd_ring_addr #(
  parameter int AW        = 32,
  parameter int IDX_W     = 12,
  parameter int ALIGN_LSB = 4,
  parameter int SLOT_LSB  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] desc_addr_o
);
  localparam int OFF_W = IDX_W + SLOT_LSB;

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [AW-1:0]    base_al;
  logic [AW-1:0]    offs;

  always_comb begin
    idx_d = idx_q;
    if (adv_i) begin
      idx_d = wrap_i ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (adv_i) begin
      idx_q <= idx_d;
    end
  end

  assign base_al     = {base_i[AW-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
  assign offs        = AW'({idx_q, {SLOT_LSB{1'b0}}});
  assign desc_addr_o = base_al + offs;
endmodule

// File: rtl/txbd_byte_pipe.sv
`timescale 1ns/1ps
module txbd_byte_pipe #(
  parameter int LW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [LW-1:0] len_i,
  input  logic          tag_last_i,
  input  logic          tag_crc_i,
  input  logic          tag_bad_i,
  input  logic          src_valid_i,
  input  logic [BW-1:0] src_data_i,
  output logic          src_ready_o,
  input  logic          tx_ready_i,
  output logic          tx_valid_o,
  output logic [BW-1:0] tx_data_o,
  output logic          tx_end_o,
  output logic          tx_frame_last_o,
  output logic          tx_add_crc_o,
  output logic          tx_bad_crc_o,
  output logic          done_o
);
  logic [LW-1:0] cnt_q, cnt_d;
  logic          beat;
  logic          at_final;

  assign beat     = en_i & src_valid_i & tx_ready_i;
  assign at_final = (cnt_q == (len_i - 1'b1));

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i) begin
      cnt_d = '0;
    end else if (beat) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign src_ready_o     = en_i & tx_ready_i;
  assign tx_valid_o      = en_i & src_valid_i;
  assign tx_data_o       = src_data_i;
  assign tx_end_o        = tx_valid_o & at_final;
  assign tx_frame_last_o = tx_end_o & tag_last_i;
  assign tx_add_crc_o    = tx_end_o & tag_crc_i;
  assign tx_bad_crc_o    = tx_end_o & tag_bad_i;
  assign done_o          = beat & at_final;
endmodule

// File: rtl/txbd_ctrl.sv
`timescale 1ns/1ps
module txbd_ctrl
  import txbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       db_hit_i,
  input  logic       rd_ack_i,
  input  txbd_desc_t rd_desc_i,
  input  logic       buf_ready_i,
  input  logic       pipe_done_i,
  input  logic       wr_ack_i,
  output logic       rd_req_o,
  output logic       buf_valid_o,
  output logic       stream_en_o,
  output logic       wr_req_o,
  output logic       adv_o,
  output txbd_desc_t desc_o
);
  walk_state_e st_q, st_d;
  logic        pend_q, pend_d;
  txbd_desc_t  desc_q;
  logic        desc_en;

  always_comb begin
    st_d    = st_q;
    desc_en = 1'b0;
    adv_o   = 1'b0;
    case (st_q)
      W_IDLE: begin
        if (db_hit_i) st_d = W_FETCH;
      end
      W_FETCH: begin
        if (rd_ack_i) begin
          desc_en = 1'b1;
          st_d    = W_CHECK;
        end
      end
      W_CHECK: begin
        if (!desc_q.status[ST_OWN]) begin
          st_d = (pend_q | db_hit_i) ? W_FETCH : W_IDLE;
        end else if (desc_q.len == '0) begin
          st_d = W_WBACK;
        end else begin
          st_d = W_BREQ;
        end
      end
      W_BREQ: begin
        if (buf_ready_i) st_d = W_STREAM;
      end
      W_STREAM: begin
        if (pipe_done_i) st_d = W_WBACK;
      end
      W_WBACK: begin
        if (wr_ack_i) begin
          adv_o = 1'b1;
          st_d  = W_FETCH;
        end
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (db_hit_i) begin
      pend_d = 1'b1;
    end else if ((st_q == W_FETCH) && rd_ack_i) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_q <= '0;
    end else if (desc_en) begin
      desc_q <= rd_desc_i;
    end
  end

  assign rd_req_o    = (st_q == W_FETCH);
  assign buf_valid_o = (st_q == W_BREQ);
  assign stream_en_o = (st_q == W_STREAM);
  assign wr_req_o    = (st_q == W_WBACK);
  assign desc_o      = desc_q;
endmodule

// File: rtl/txbd_walker.sv
`timescale 1ns/1ps
module txbd_walker
  import txbd_pkg::*;
#(
  parameter int IDX_W  = 12,
  parameter int DB_W   = 32,
  parameter int DB_BIT = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TXBD_AW-1:0]     ring_base_i,
  input  logic                   db_we_i,
  input  logic [DB_W-1:0]        db_wdata_i,
  output logic                   dfetch_req_o,
  output logic [TXBD_AW-1:0]     dfetch_addr_o,
  input  logic                   dfetch_ack_i,
  input  logic [TXBD_DESC_W-1:0] dfetch_data_i,
  output logic                   bufrd_valid_o,
  input  logic                   bufrd_ready_i,
  output logic [TXBD_AW-1:0]     bufrd_addr_o,
  output logic [TXBD_LW-1:0]     bufrd_len_o,
  input  logic                   src_valid_i,
  input  logic [7:0]             src_data_i,
  output logic                   src_ready_o,
  output logic                   tx_valid_o,
  input  logic                   tx_ready_i,
  output logic [7:0]             tx_data_o,
  output logic                   tx_end_o,
  output logic                   tx_frame_last_o,
  output logic                   tx_add_crc_o,
  output logic                   tx_bad_crc_o,
  output logic                   swb_req_o,
  output logic [TXBD_AW-1:0]     swb_addr_o,
  output logic [TXBD_SW-1:0]     swb_data_o,
  input  logic                   swb_ack_i
);
  logic          db_hit;
  logic          adv;
  logic          stream_en;
  logic          pipe_done;
  logic [TXBD_AW-1:0] desc_addr;
  txbd_desc_t    cur;
  txbd_desc_t    fetched;

  assign db_hit  = db_we_i & db_wdata_i[DB_BIT];
  assign fetched = txbd_desc_t'(dfetch_data_i);

  txbd_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .db_hit_i    (db_hit),
    .rd_ack_i    (dfetch_ack_i),
    .rd_desc_i   (fetched),
    .buf_ready_i (bufrd_ready_i),
    .pipe_done_i (pipe_done),
    .wr_ack_i    (swb_ack_i),
    .rd_req_o    (dfetch_req_o),
    .buf_valid_o (bufrd_valid_o),
    .stream_en_o (stream_en),
    .wr_req_o    (swb_req_o),
    .adv_o       (adv),
    .desc_o      (cur)
  );

  txbd_ring_addr #(
    .AW    (TXBD_AW),
    .IDX_W (IDX_W)
  ) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .base_i      (ring_base_i),
    .adv_i       (adv),
    .wrap_i      (cur.status[ST_WRAP]),
    .desc_addr_o (desc_addr)
  );

  txbd_byte_pipe #(
    .LW (TXBD_LW),
    .BW (8)
  ) u_pipe (
    .clk             (clk),
    .rst_n           (rst_n),
    .en_i            (stream_en),
    .len_i           (cur.len),
    .tag_last_i      (cur.status[ST_LAST]),
    .tag_crc_i       (cur.status[ST_TXCRC]),
    .tag_bad_i       (cur.status[ST_BADCRC]),
    .src_valid_i     (src_valid_i),
    .src_data_i      (src_data_i),
    .src_ready_o     (src_ready_o),
    .tx_ready_i      (tx_ready_i),
    .tx_valid_o      (tx_valid_o),
    .tx_data_o       (tx_data_o),
    .tx_end_o        (tx_end_o),
    .tx_frame_last_o (tx_frame_last_o),
    .tx_add_crc_o    (tx_add_crc_o),
    .tx_bad_crc_o    (tx_bad_crc_o),
    .done_o          (pipe_done)
  );

  assign dfetch_addr_o = desc_addr;
  assign swb_addr_o    = desc_addr;
  assign bufrd_addr_o  = cur.ptr;
  assign bufrd_len_o   = cur.len;

  always_comb begin
    swb_data_o         = cur.status;
    swb_data_o[ST_OWN] = 1'b0;
  end
endmodule

// File: rtl/txbd_walker_chk.sv
`timescale 1ns/1ps
module txbd_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dfetch_req_o,
  input logic [31:0] dfetch_addr_o,
  input logic        dfetch_ack_i,
  input logic        bufrd_valid_o,
  input logic        bufrd_ready_i,
  input logic [31:0] bufrd_addr_o,
  input logic [15:0] bufrd_len_o,
  input logic        tx_valid_o,
  input logic        tx_end_o,
  input logic        tx_frame_last_o,
  input logic        tx_add_crc_o,
  input logic        tx_bad_crc_o,
  input logic        swb_req_o,
  input logic [31:0] swb_addr_o,
  input logic [15:0] swb_data_o,
  input logic        swb_ack_i
);
  p_one_activity_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dfetch_req_o, bufrd_valid_o, tx_valid_o, swb_req_o}));

  p_fetch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dfetch_req_o && !dfetch_ack_i |=> dfetch_req_o && $stable(dfetch_addr_o));

  p_fetch_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dfetch_req_o |-> dfetch_addr_o[2:0] == 3'b000);

  p_breq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bufrd_valid_o && !bufrd_ready_i |=>
      bufrd_valid_o && $stable(bufrd_addr_o) && $stable(bufrd_len_o));

  p_no_zero_breq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bufrd_valid_o |-> bufrd_len_o != 16'd0);

  p_side_final_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_end_o |-> !(tx_frame_last_o || tx_add_crc_o || tx_bad_crc_o));

  p_wb_own_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swb_req_o |-> !swb_data_o[15]);

  p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swb_req_o && !swb_ack_i |=>
      swb_req_o && $stable(swb_addr_o) && $stable(swb_data_o));
endmodule

bind txbd_walker txbd_walker_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .dfetch_req_o    (dfetch_req_o),
  .dfetch_addr_o   (dfetch_addr_o),
  .dfetch_ack_i    (dfetch_ack_i),
  .bufrd_valid_o   (bufrd_valid_o),
  .bufrd_ready_i   (bufrd_ready_i),
  .bufrd_addr_o    (bufrd_addr_o),
  .bufrd_len_o     (bufrd_len_o),
  .tx_valid_o      (tx_valid_o),
  .tx_end_o        (tx_end_o),
  .tx_frame_last_o (tx_frame_last_o),
  .tx_add_crc_o    (tx_add_crc_o),
  .tx_bad_crc_o    (tx_bad_crc_o),
  .swb_req_o       (swb_req_o),
  .swb_addr_o      (swb_addr_o),
  .swb_data_o      (swb_data_o),
  .swb_ack_i       (swb_ack_i)
);

// File: tb/txbd_walker_tb_top.sv
`timescale 1ns/1ps
module txbd_walker_tb_top;
  localparam logic [31:0] BASE    = 32'h4000_0107;
  localparam logic [31:0] BASE_AL = 32'h4000_0100;
  localparam int          WD_CYC  = 150000;

  logic        clk;
  logic        rst_n;
  logic        db_we;
  logic [31:0] db_wdata;
  logic        dfetch_req, dfetch_ack;
  logic [31:0] dfetch_addr;
  logic [63:0] dfetch_data;
  logic        bufrd_valid, bufrd_ready;
  logic [31:0] bufrd_addr;
  logic [15:0] bufrd_len;
  logic        src_valid, src_ready;
  logic [7:0]  src_data;
  logic        tx_valid, tx_ready, tx_end, tx_flast, tx_acrc, tx_bcrc;
  logic [7:0]  tx_data;
  logic        swb_req, swb_ack;
  logic [31:0] swb_addr;
  logic [15:0] swb_data;

  txbd_walker dut_i (
    .clk (clk), .rst_n (rst_n), .ring_base_i (BASE),
    .db_we_i (db_we), .db_wdata_i (db_wdata),
    .dfetch_req_o (dfetch_req), .dfetch_addr_o (dfetch_addr),
    .dfetch_ack_i (dfetch_ack), .dfetch_data_i (dfetch_data),
    .bufrd_valid_o (bufrd_valid), .bufrd_ready_i (bufrd_ready),
    .bufrd_addr_o (bufrd_addr), .bufrd_len_o (bufrd_len),
    .src_valid_i (src_valid), .src_data_i (src_data), .src_ready_o (src_ready),
    .tx_valid_o (tx_valid), .tx_ready_i (tx_ready), .tx_data_o (tx_data),
    .tx_end_o (tx_end), .tx_frame_last_o (tx_flast),
    .tx_add_crc_o (tx_acrc), .tx_bad_crc_o (tx_bcrc),
    .swb_req_o (swb_req), .swb_addr_o (swb_addr), .swb_data_o (swb_data),
    .swb_ack_i (swb_ack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // bench ring memory
  logic [15:0] m_st  [8];
  logic [15:0] m_len [8];
  logic [31:0] m_ptr [8];

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  // bench model state
  int          m_idx = 0;
  int          phase = 0;   // 0 expect fetch, 1 buf req, 2 bytes, 3 write-back
  bit          stopped = 1;
  int          stop_cnt = 0;
  int          fetch_cnt = 0;
  int          wb_cnt = 0;
  logic [15:0] c_st, c_len;
  logic [31:0] c_ptr;
  int          pos = 0;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic int slot_of(input logic [31:0] a);
    return int'(((a - BASE_AL) >> 3) & 32'd7);
  endfunction

  function automatic int next_slot(input int i, input logic [15:0] st);
    return st[13] ? 0 : ((i + 1) & 7);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic summary;
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // drivers: respond at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      dfetch_ack <= 1'b0; dfetch_data <= '0; bufrd_ready <= 1'b0;
      src_valid <= 1'b0; src_data <= '0; tx_ready <= 1'b0; swb_ack <= 1'b0;
    end else begin
      dfetch_ack  <= dfetch_req && ($urandom % 4 != 0);
      dfetch_data <= {m_st[slot_of(dfetch_addr)], m_len[slot_of(dfetch_addr)],
                      m_ptr[slot_of(dfetch_addr)]};
      bufrd_ready <= bufrd_valid && ($urandom % 3 != 0);
      src_valid   <= (phase == 2) && (pos < int'(c_len)) && ($urandom % 4 != 0);
      src_data    <= pat(c_ptr + 32'(pos));
      tx_ready    <= ($urandom % 4 != 0);
      swb_ack     <= swb_req && ($urandom % 3 != 0);
    end
  end

  // monitor: sample just before the rising edge
  always begin
    @(negedge clk);
    #1.5;
    if (rst_n) begin
      if (dfetch_req && dfetch_ack) begin
        fetch_cnt++;
        chk(dfetch_addr == BASE_AL + 32'(m_idx * 8), "R8", "fetch address",
            dfetch_addr, BASE_AL + 32'(m_idx * 8));
        chk(phase == 0, "R11", "fetch out of order", 32'(phase), 0);
        chk(!stopped, "R9", "fetch while parked", 32'(stopped), 0);
        c_st = m_st[m_idx]; c_len = m_len[m_idx]; c_ptr = m_ptr[m_idx];
        if (!c_st[15]) begin
          stopped = 1; stop_cnt++;
        end else begin
          phase = (c_len == 16'd0) ? 3 : 1;
        end
      end
      if (bufrd_valid && bufrd_ready) begin
        chk(phase == 1, (c_len == 0) ? "R10" : "R4", "unexpected buffer request",
            32'(phase), 1);
        chk(bufrd_addr == c_ptr, "R4", "buffer address", bufrd_addr, c_ptr);
        chk(bufrd_len == c_len, "R4", "buffer length", 32'(bufrd_len), 32'(c_len));
        pos = 0; phase = 2;
      end
      if (tx_valid && tx_ready) begin
        chk(phase == 2, "R5", "unexpected byte", 32'(phase), 2);
        chk(tx_data == pat(c_ptr + 32'(pos)), "R5", "byte value",
            32'(tx_data), 32'(pat(c_ptr + 32'(pos))));
        chk(src_ready, "R5", "source handshake", 32'(src_ready), 1);
        if (pos == int'(c_len) - 1) begin
          chk({tx_end, tx_flast, tx_acrc, tx_bcrc} == {1'b1, c_st[11], c_st[10], c_st[9]},
              "R6", "final-byte sideband", 32'({tx_end, tx_flast, tx_acrc, tx_bcrc}),
              32'({1'b1, c_st[11], c_st[10], c_st[9]}));
          phase = 3;
        end else begin
          chk({tx_end, tx_flast, tx_acrc, tx_bcrc} == 4'b0, "R6", "mid-buffer sideband",
              32'({tx_end, tx_flast, tx_acrc, tx_bcrc}), 0);
        end
        pos++;
      end
      if (swb_req && swb_ack) begin
        wb_cnt++;
        chk(phase == 3, (c_len == 0) ? "R10" : "R7", "write-back out of order",
            32'(phase), 3);
        chk(swb_addr == BASE_AL + 32'(m_idx * 8), "R7", "write-back address",
            swb_addr, BASE_AL + 32'(m_idx * 8));
        chk(swb_data == (c_st & 16'h7FFF), "R7", "write-back status",
            32'(swb_data), 32'(c_st & 16'h7FFF));
        m_st[m_idx] = c_st & 16'h7FFF;
        m_idx = next_slot(m_idx, c_st);
        phase = 0;
      end
      if (db_we && db_wdata[24]) stopped = 0;
    end
  end

  task automatic ring(input logic [31:0] v);
    @(negedge clk);
    db_we <= 1'b1; db_wdata <= v;
    @(negedge clk);
    db_we <= 1'b0; db_wdata <= '0;
  endtask

  task automatic wait_stop(input int prev, input string rq);
    int f0;
    wait (stop_cnt > prev && stopped);
    f0 = fetch_cnt;
    repeat (30) @(negedge clk);
    chk(fetch_cnt == f0, rq, "no fetch while parked", 32'(fetch_cnt), 32'(f0));
    chk(phase == 0, rq, "idle phase after stop", 32'(phase), 0);
  endtask

  task automatic set_desc(input int i, input logic [15:0] st, input logic [15:0] ln,
                          input logic [31:0] p);
    m_st[i] = st; m_len[i] = ln; m_ptr[i] = p;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  initial begin
    int s, w0, f0, k;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) set_desc(i, 16'h0000, 16'd0, 32'h0);
    m_st[7] = 16'h2000;
    db_we = 1'b0; db_wdata = '0; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!dfetch_req, "R1", "fetch request in reset", 32'(dfetch_req), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!dfetch_req, "R1", "fetch request after reset", 32'(dfetch_req), 0);
    chk(!bufrd_valid, "R1", "buffer request after reset", 32'(bufrd_valid), 0);
    chk(!tx_valid, "R1", "byte valid after reset", 32'(tx_valid), 0);
    chk(!swb_req, "R1", "write-back after reset", 32'(swb_req), 0);

    // R3 R4 R6: three owned buffers with different flag sets, then a parked slot
    set_desc(0, 16'h8C00, 16'd5, 32'h8000_1000);
    set_desc(1, 16'h8200, 16'd1, 32'h8000_2003);
    set_desc(2, 16'h8E00, 16'd3, 32'h8000_30F0);
    s = stop_cnt;
    ring(32'h0100_0000);
    wait_stop(s, "R9");
    chk(m_idx == 3, "R3", "parked slot", 32'(m_idx), 3);
    chk(wb_cnt == 3, "R7", "write-back count", 32'(wb_cnt), 3);

    // R2: start writes without bit 24 are ignored
    f0 = fetch_cnt;
    ring(32'h00FF_FFFF);
    ring(32'h0200_0000);
    repeat (30) @(negedge clk);
    chk(fetch_cnt == f0, "R2", "ignored start write", 32'(fetch_cnt), 32'(f0));

    // R10: zero-length owned descriptor
    set_desc(3, 16'h8800, 16'd0, 32'h8000_4000);
    set_desc(4, 16'h8400, 16'd2, 32'h8000_5000);
    s = stop_cnt; w0 = wb_cnt;
    ring(32'h0100_0000);
    wait_stop(s, "R10");
    chk(wb_cnt == w0 + 2, "R10", "write-backs incl. empty slot", 32'(wb_cnt), 32'(w0 + 2));

    // R8: wrap bit on slot 6 returns to base
    set_desc(5, 16'h8000, 16'd4, 32'h8000_6000);
    set_desc(6, 16'hA800, 16'd2, 32'h8000_7000);
    set_desc(0, 16'h8400, 16'd1, 32'h8000_8000);
    set_desc(1, 16'h0000, 16'd9, 32'h8000_9000);
    s = stop_cnt;
    ring(32'h0100_0000);
    wait_stop(s, "R8");
    chk(m_idx == 1, "R8", "slot after wrap", 32'(m_idx), 1);
    chk(m_st[6] == 16'h2800, "R7", "wrap bit kept", 32'(m_st[6]), 32'h2800);

    // R9: start command while busy picks up a newly owned slot
    set_desc(1, 16'h8C00, 16'd20, 32'h8000_A000);
    set_desc(2, 16'h0000, 16'd3, 32'h8000_B000);
    s = stop_cnt; w0 = wb_cnt;
    ring(32'h0100_0000);
    wait (phase == 2 && pos > 5);
    set_desc(2, 16'h8400, 16'd3, 32'h8000_B000);
    ring(32'h0100_0000);
    wait_stop(s, "R9");
    chk(wb_cnt == w0 + 2, "R9", "busy start not lost", 32'(wb_cnt), 32'(w0 + 2));

    // random rounds over the full 8-slot ring
    for (int i = 0; i < 8; i++) m_st[i] = 16'h0000;
    m_st[7] = 16'h2000;
    for (int r = 0; r < 8; r++) begin
      int j;
      k = 1 + int'($urandom % 6);
      j = m_idx;
      for (int n = 0; n < k; n++) begin
        m_st[j]  = 16'h8000 | (m_st[j] & 16'h2000) | 16'({$urandom % 8, 9'b0});
        m_len[j] = 16'($urandom % 10);
        m_ptr[j] = 32'h8000_0000 + ($urandom % 65536);
        j = next_slot(j, m_st[j]);
      end
      m_st[j] = m_st[j] & 16'h2000;
      s = stop_cnt; w0 = wb_cnt;
      ring(32'h0100_0000 | ($urandom & 32'h00FF_FFFF));
      wait_stop(s, "R9");
      chk(wb_cnt == w0 + k, "R4", "random round buffers", 32'(wb_cnt), 32'(w0 + k));
    end

    summary();
  end
endmodule